// File: doc/BRIEF.md
# Slave serial audio transmit port with slot sharing

This block serialises one 20-bit stereo sample pair per audio frame onto a single data line. It never generates clocks: the bit clock and the frame clock come from an external master, and the block runs from a faster system clock. It synchronises both serial clocks into the system domain and finds their edges there. A static mode input chooses between two-channel I2S framing and an eight-slot TDM frame. In TDM a two-bit selector picks which pair of neighbouring slots the block owns.

The data line is driven only while the block is sending its own sample bits. It is released for every other bit period, so several transmitters can share one TDM line. A separate enable output shows when the pin is driven. Both channels of a frame come from one captured pair. The output stays released after reset until the block has seen a complete frame.

Top module: `ser_slot_tx`

## Requirements
- R1: While rst_n is low, and after its release until any serial clock activity, sdata_oe is 0 and sdata is high impedance.
- R2: With mode_i2s=1, a low frame clock marks the left channel. The left sample's MSB is driven in the bit period after the one in which the frame clock fell, and the remaining bits follow MSB first.
- R3: With mode_i2s=1, a high frame clock marks the right channel. The right sample's MSB is driven one bit period after the frame clock rose, MSB first.
- R4: Each channel drives exactly 20 consecutive bit periods and then releases the line for the rest of that channel. This holds for both 32 and 64 bit periods per channel.
- R5: With mode_i2s=0, a frame begins with the bit period in which the frame clock is first sampled high after being low. The frame holds 8 slots of 32 bit periods, numbered 0 to 7. For slot_pair=k, the left sample goes in slot 2k and the right sample in slot 2k+1, with the MSB in the first period of the slot and no delay.
- R6: With mode_i2s=0, every slot not selected, and periods 20 to 31 of the selected slots, leave the line released (sdata_oe=0).
- R7: sdata and sdata_oe change only after a falling bit-clock edge. The value seen just before a rising edge is still present at the end of the high phase.
- R8: After reset the line is not driven until a complete frame has been observed. In I2S this is a second left-channel start. In TDM it is one full 256-period frame counted from a frame start. Earlier frames stay silent.
- R9: The sample pair is captured once per frame: in I2S when the left-channel start is detected, in TDM when the frame's first bit period is launched. Later changes to pcm_left or pcm_right in the same frame appear only in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock |
| mode_i2s | input | 1 | 1 selects I2S framing, 0 selects 8-slot TDM |
| slot_pair | input | 2 | TDM slot pair owned by this block |
| pcm_left | input | 20 | Left sample, two's complement |
| pcm_right | input | 20 | Right sample, two's complement |
| sdata | output | 1 | Serial data, high impedance when not driving |
| sdata_oe | output | 1 | 1 while sdata is driven |

## Verification
The bench probes the one-period offset that separates I2S from TDM. A design that applied the I2S delay in TDM, or left it out in I2S, would shift every bit and lose the MSB or the LSB. It counts the driven periods per channel at two clock ratios, which catches an off-by-one that drives a 21st bit onto a neighbour's slot. It walks slot_pair across values to catch a wrong slot decode. It changes the sample inputs mid-frame to catch a design that reads live inputs and mixes two sample instants. It also checks that the first frames after reset stay silent, which catches a design that drives a truncated first frame onto a shared line.

// File: rtl/ser_slot_pkg.sv
package ser_slot_pkg;

   typedef enum logic {
      FMT_TDM = 1'b0,
      FMT_I2S = 1'b1
   } ser_fmt_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } clk_evt_t;

endpackage

// File: rtl/so_sync.sv
module so_sync #(
   parameter int unsigned W = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 1) begin : g_bad_stages
      $error("so_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= din;
      end
      assign dout = q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
   end

endmodule

// File: rtl/so_frame_track.sv
module so_frame_track #(
   parameter int unsigned FRAME_LEN = 256,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i2s,
   input  logic             rise,
   input  logic             lr_lvl,
   output logic [CNT_W-1:0] cnt,
   output logic             chan,
   output logic             frame_start,
   output logic             locked
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   logic lr_q;
   logic started;
   logic restart;
   logic tdm_start, i2s_left, i2s_turn;

   assign tdm_start   = rise & ~lr_q & lr_lvl;
   assign i2s_left    = rise & lr_q & ~lr_lvl;
   assign i2s_turn    = rise & (lr_q ^ lr_lvl);
   assign frame_start = mode_i2s ? i2s_left : tdm_start;
   assign restart     = mode_i2s ? i2s_turn : tdm_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q    <= 1'b0;
         cnt     <= '0;
         chan    <= 1'b0;
         started <= 1'b0;
         locked  <= 1'b0;
      end else begin
         if (rise) lr_q <= lr_lvl;
         if (restart) begin
            cnt  <= '0;
            chan <= lr_lvl;
         end else if (rise) begin
            if (cnt == LAST) cnt <= mode_i2s ? LAST : '0;
            else             cnt <= cnt + 1'b1;
         end
         if (frame_start) started <= 1'b1;
         if (mode_i2s && frame_start && started) locked <= 1'b1;
         if (!mode_i2s && rise && !restart && started && cnt == LAST - 1'b1)
            locked <= 1'b1;
      end
   end

   // R5: once locked in TDM, every frame start arrives exactly one frame length later
   p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i2s && frame_start && locked) |-> cnt == LAST);

   // R8: lock is never lost without a reset
   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

endmodule

// File: rtl/so_bit_sched.sv
module so_bit_sched #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned SLOT_BITS = 32,
   parameter int unsigned SLOTS = 8,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i2s,
   input  logic [SEL_W-1:0]  slot_pair,
   input  logic              fall,
   input  logic              frame_start,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              chan,
   input  logic              locked,
   input  logic [DATA_W-1:0] pcm_left,
   input  logic [DATA_W-1:0] pcm_right,
   output logic              sd,
   output logic              oe
);

   localparam int unsigned SLOT_LOG = $clog2(SLOT_BITS);
   localparam int unsigned IDX_W    = CNT_W - SLOT_LOG;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS * SLOT_BITS - 1);

   logic [CNT_W-1:0]    nxt;
   logic [IDX_W-1:0]    slot_idx;
   logic [SLOT_LOG-1:0] pos;
   logic                drive_i2s, drive_tdm, drive;
   logic                ch_sel;
   logic [CNT_W-1:0]    bit_no, shift_by;
   logic                latch_tdm;
   logic [DATA_W-1:0]   hold_l, hold_r, word, shifted;

   // index of the bit period that the coming falling edge opens
   assign nxt      = (cnt == LAST) ? (mode_i2s ? LAST : '0) : cnt + 1'b1;
   assign slot_idx = nxt[CNT_W-1:SLOT_LOG];
   assign pos      = nxt[SLOT_LOG-1:0];

   assign drive_i2s = (nxt >= CNT_W'(1)) && (nxt <= CNT_W'(DATA_W));
   assign drive_tdm = (slot_idx[IDX_W-1:1] == slot_pair) && (pos < SLOT_LOG'(DATA_W));
   assign drive     = locked & (mode_i2s ? drive_i2s : drive_tdm);
   assign ch_sel    = mode_i2s ? chan : slot_idx[0];
   assign bit_no    = mode_i2s ? nxt - 1'b1 : {{(CNT_W-SLOT_LOG){1'b0}}, pos};
   assign shift_by  = CNT_W'(DATA_W - 1) - bit_no;

   assign latch_tdm = !mode_i2s && fall && locked && (nxt == '0);
   assign word      = ch_sel ? (latch_tdm ? pcm_right : hold_r)
                             : (latch_tdm ? pcm_left  : hold_l);
   assign shifted   = word >> shift_by;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         sd     <= 1'b0;
         oe     <= 1'b0;
      end else begin
         if ((mode_i2s && frame_start) || latch_tdm) begin
            hold_l <= pcm_left;
            hold_r <= pcm_right;
         end
         if (fall) begin
            oe <= drive;
            sd <= drive & shifted[0];
         end
      end
   end

   // checker state: length of the current run of driven bit periods
   logic [CNT_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= '0;
      else if (fall && oe)   run_q <= run_q + 1'b1;
      else if (fall)         run_q <= '0;
   end

   // R4: no run of driven bit periods exceeds the sample width
   p_run_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_W'(DATA_W));

   // R8: the pin is never driven before the frame tracker has locked
   p_oe_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> locked);

   // R7: pin value and enable move only after a falling bit-clock edge
   p_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sd != $past(sd) || oe != $past(oe)) |-> $past(fall));

endmodule

// File: rtl/ser_slot_tx.sv
module ser_slot_tx #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned SLOT_BITS = 32,
   parameter int unsigned SLOTS = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W = $clog2(SLOTS) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              lrclk,
   input  logic              mode_i2s,
   input  logic [SEL_W-1:0]  slot_pair,
   input  logic [DATA_W-1:0] pcm_left,
   input  logic [DATA_W-1:0] pcm_right,
   output tri                sdata,
   output logic              sdata_oe
);
   import ser_slot_pkg::*;

   localparam int unsigned FRAME_LEN = SLOTS * SLOT_BITS;
   localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

   if (SLOTS < 4 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("ser_slot_tx: SLOTS must be a power of two of at least 4");
   end
   if ((SLOT_BITS & (SLOT_BITS - 1)) != 0 || SLOT_BITS < 2) begin : g_bad_slot_bits
      $error("ser_slot_tx: SLOT_BITS must be a power of two");
   end
   if (DATA_W < 1 || DATA_W >= SLOT_BITS) begin : g_bad_width
      $error("ser_slot_tx: DATA_W must be below SLOT_BITS");
   end

   logic [1:0] sync_q;
   logic       bclk_d;
   clk_evt_t   evt;
   logic [CNT_W-1:0] cnt;
   logic       chan, frame_start, locked, sd, oe;

   so_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({bclk, lrclk}), .dout(sync_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b1;
      else        bclk_d <= sync_q[1];
   end
   assign evt.rise = sync_q[1] & ~bclk_d;
   assign evt.fall = ~sync_q[1] & bclk_d;

   so_frame_track #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .mode_i2s(mode_i2s), .rise(evt.rise),
      .lr_lvl(sync_q[0]), .cnt(cnt), .chan(chan),
      .frame_start(frame_start), .locked(locked));

   so_bit_sched #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS),
                  .CNT_W(CNT_W), .SEL_W(SEL_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .mode_i2s(mode_i2s), .slot_pair(slot_pair),
      .fall(evt.fall), .frame_start(frame_start), .cnt(cnt), .chan(chan),
      .locked(locked), .pcm_left(pcm_left), .pcm_right(pcm_right),
      .sd(sd), .oe(oe));

   assign sdata    = oe ? sd : 1'bz;
   assign sdata_oe = oe;

endmodule

// File: tb/sim_ser_slot_tx.sv
module sim_ser_slot_tx;

   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        lrclk = 1'b0;
   logic        mode_i2s = 1'b1;
   logic [1:0]  slot_pair = 2'd0;
   logic [19:0] pcm_left = '0;
   logic [19:0] pcm_right = '0;
   tri          sdata;
   logic        sdata_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int unstable = 0;
   logic cap_d [0:511];
   logic cap_oe [0:511];

   always #10 clk = ~clk;

   ser_slot_tx u0 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
      .mode_i2s(mode_i2s), .slot_pair(slot_pair), .pcm_left(pcm_left),
      .pcm_right(pcm_right), .sdata(sdata), .sdata_oe(sdata_oe));

   task automatic chk(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic fmt);
      @(negedge clk);
      rst_n = 1'b0;
      bclk = 1'b1;
      lrclk = 1'b0;
      mode_i2s = fmt;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // one bit period: falling edge, low phase, sample, rising edge, high phase, re-sample
   task automatic run_period(input logic lr, input int idx);
      logic a_d, a_oe;
      @(negedge clk);
      bclk = 1'b0;
      lrclk = lr;
      repeat (H - 1) @(negedge clk);
      a_d = sdata;
      a_oe = sdata_oe;
      cap_d[idx] = a_d;
      cap_oe[idx] = a_oe;
      @(negedge clk);
      bclk = 1'b1;
      repeat (H - 1) @(negedge clk);
      if (sdata_oe !== a_oe || (a_oe && sdata !== a_d)) unstable++;
   endtask

   task automatic i2s_frame(input int per_ch, input int chg_at,
                            input logic [19:0] nl, input logic [19:0] nr);
      for (int p = 0; p < 2 * per_ch; p++) begin
         if (p == chg_at) begin pcm_left = nl; pcm_right = nr; end
         run_period(p >= per_ch, p);
      end
   endtask

   task automatic tdm_frame(input int chg_at, input logic [19:0] nl, input logic [19:0] nr);
      for (int p = 0; p < 256; p++) begin
         if (p == chg_at) begin pcm_left = nl; pcm_right = nr; end
         run_period(p == 0, p);
      end
   endtask

   task automatic check_silent(input int n, input string req);
      int cnt = 0;
      for (int p = 0; p < n; p++) if (cap_oe[p] !== 1'b0) cnt++;
      chk(req, cnt, 0, "driven periods in pre-lock frame");
   endtask

   task automatic check_i2s(input int per_ch, input logic [19:0] l, input logic [19:0] r, input string tag);
      int oe_err = 0, l_err = 0, r_err = 0;
      for (int p = 0; p < 2 * per_ch; p++) begin
         int q = (p >= per_ch) ? p - per_ch : p;
         logic eo = (q >= 1 && q <= 20);
         if (cap_oe[p] !== eo) oe_err++;
         else if (eo && p < per_ch && cap_d[p] !== l[20 - q]) l_err++;
         else if (eo && p >= per_ch && cap_d[p] !== r[20 - q]) r_err++;
      end
      chk("R4", oe_err, 0, {tag, " enable pattern errors"});
      chk("R2", l_err, 0, {tag, " left bit errors"});
      chk("R3", r_err, 0, {tag, " right bit errors"});
      chk("R7", unstable, 0, {tag, " changes after rising edge"});
      unstable = 0;
   endtask

   task automatic check_tdm(input int sel, input logic [19:0] l, input logic [19:0] r, input string tag);
      int oe_err = 0, d_err = 0;
      for (int p = 0; p < 256; p++) begin
         int slot = p / 32;
         int pos = p % 32;
         logic eo = ((slot / 2) == sel) && (pos < 20);
         if (cap_oe[p] !== eo) oe_err++;
         else if (eo && cap_d[p] !== ((slot % 2) ? r[19 - pos] : l[19 - pos])) d_err++;
      end
      chk("R6", oe_err, 0, {tag, " enable pattern errors"});
      chk("R5", d_err, 0, {tag, " slot bit errors"});
      chk("R7", unstable, 0, {tag, " changes after rising edge"});
      unstable = 0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", int'(sdata_oe), 0, "enable during reset");
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1", int'(sdata_oe), 0, "enable after reset, idle clocks");
   endtask

   task automatic t_i2s_basic;
      do_reset(1'b1);
      pcm_left = 20'hA5C3E; pcm_right = 20'h1B2D4;
      i2s_frame(32, -1, '0, '0);
      check_silent(64, "R8");
      unstable = 0;
      i2s_frame(32, -1, '0, '0);
      check_silent(64, "R8");
      unstable = 0;
      i2s_frame(32, -1, '0, '0);
      check_i2s(32, 20'hA5C3E, 20'h1B2D4, "i2s first locked frame");
      pcm_left = 20'h80001; pcm_right = 20'h7FFFE;
      i2s_frame(32, -1, '0, '0);
      check_i2s(32, 20'h80001, 20'h7FFFE, "i2s extremes");
   endtask

   task automatic t_i2s_wide;
      pcm_left = 20'hF0F0F; pcm_right = 20'h3C96A;
      i2s_frame(64, -1, '0, '0);
      check_i2s(64, 20'hF0F0F, 20'h3C96A, "i2s 64 periods per channel");
   endtask

   task automatic t_i2s_hold;
      pcm_left = 20'h12345; pcm_right = 20'hEDCBA;
      i2s_frame(32, 10, 20'h55555, 20'hAAAAA);
      check_i2s(32, 20'h12345, 20'hEDCBA, "R9 i2s mid-frame change ignored");
      i2s_frame(32, -1, '0, '0);
      check_i2s(32, 20'h55555, 20'hAAAAA, "R9 i2s next frame picks new pair");
   endtask

   task automatic t_tdm_basic;
      slot_pair = 2'd0;
      do_reset(1'b0);
      pcm_left = 20'hC0FFE; pcm_right = 20'h0BEEF;
      tdm_frame(-1, '0, '0);
      check_silent(256, "R8");
      unstable = 0;
      tdm_frame(-1, '0, '0);
      check_tdm(0, 20'hC0FFE, 20'h0BEEF, "tdm pair 0");
   endtask

   task automatic t_tdm_sel;
      slot_pair = 2'd3;
      pcm_left = 20'h9E371; pcm_right = 20'h4A6B2;
      tdm_frame(-1, '0, '0);
      check_tdm(3, 20'h9E371, 20'h4A6B2, "tdm pair 3");
      slot_pair = 2'd1;
      pcm_left = 20'h00001; pcm_right = 20'h80000;
      tdm_frame(-1, '0, '0);
      check_tdm(1, 20'h00001, 20'h80000, "tdm pair 1");
   endtask

   task automatic t_tdm_hold;
      slot_pair = 2'd0;
      pcm_left = 20'h6D2F1; pcm_right = 20'hB3A09;
      tdm_frame(40, 20'h11111, 20'h22222);
      check_tdm(0, 20'h6D2F1, 20'hB3A09, "R9 tdm mid-frame change ignored");
      tdm_frame(-1, '0, '0);
      check_tdm(0, 20'h11111, 20'h22222, "R9 tdm next frame picks new pair");
   endtask

   initial begin
      t_reset();
      t_i2s_basic();
      t_i2s_wide();
      t_i2s_hold();
      t_tdm_basic();
      t_tdm_sel();
      t_tdm_hold();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule